// File: doc/BRIEF.md
# DMA Request and Acknowledge Handshake for Receive and Transmit FIFOs

This block sits between a pair of FIFOs and an external DMA controller. It raises a receive request while the receive FIFO holds words, and a transmit request while the transmit FIFO has free space. When the controller answers with an active-low acknowledge, the block steers the bus access to the FIFO. Normal register decoding is bypassed, and one read or write pulse goes to the FIFO once the access ends.

A request is pulled back early. It drops in the same cycle as the access that moves the last available word begins, so the controller never issues one transfer too many. After that the request stays down until the FIFO state moves the other way: a new word arrives in the receive FIFO, or space is freed in the transmit FIFO. The fill counts come from the FIFOs themselves. The bus strobes are active low and are sampled on the block clock.

Top module: `dma_req_handshake`

## Requirements
- R1: rx_req is high while rx_count is nonzero, unless a hold from R3 is pending or a last-word read (R2) is in progress. It is low while rx_count is zero.
- R2: While rx_count equals 1, rx_req falls in the same cycle that a receive access begins. A receive access is rx_ack_n=0 together with rd_n=0.
- R3: After a last-word receive access has been seen at a clock edge, rx_req stays low. It returns at the first clock edge at which rx_count is larger than its value at the previous edge. This holds even if that rise happens during the access.
- R4: Each receive access produces exactly one rx_pop pulse, one clock wide. The pulse is registered and starts at the first rising edge at which the access is no longer present. rx_ack_n low without rd_n low produces no pulse.
- R5: rx_sel equals the inverse of rx_ack_n and tx_sel equals the inverse of tx_ack_n, whatever the values of decode_hit, the strobes and the counts. reg_sel is low whenever either acknowledge is low.
- R6: tx_req is high while tx_free is nonzero, unless a hold from R8 is pending or a last-word write (R7) is in progress. It is low while tx_free is zero.
- R7: While tx_free equals 1, tx_req falls in the same cycle that a transmit access begins. A transmit access is tx_ack_n=0 together with wr_n=0.
- R8: After a last-word transmit access has been seen at a clock edge, tx_req stays low. It returns at the first clock edge at which tx_free is larger than its value at the previous edge.
- R9: Each transmit access produces exactly one tx_push pulse, one clock wide, with the same timing as R4. tx_ack_n low with only rd_n low, or with no strobe at all, produces no pulse.
- R10: When both acknowledges are high, reg_sel follows decode_hit.
- R11: While rst_n is low, rx_req, tx_req, rx_pop and tx_push are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_count | input | CNT_W | Words currently held in the receive FIFO |
| tx_free | input | CNT_W | Free word slots in the transmit FIFO |
| rx_ack_n | input | 1 | Receive acknowledge from the DMA controller, active low |
| tx_ack_n | input | 1 | Transmit acknowledge from the DMA controller, active low |
| rd_n | input | 1 | Bus read strobe, active low |
| wr_n | input | 1 | Bus write strobe, active low |
| decode_hit | input | 1 | Normal address and chip-select decode result |
| rx_req | output | 1 | Receive DMA request, active high |
| tx_req | output | 1 | Transmit DMA request, active high |
| rx_sel | output | 1 | Steers read data from the receive FIFO output |
| tx_sel | output | 1 | Steers write data into the transmit FIFO |
| reg_sel | output | 1 | Normal register access enable after acknowledge override |
| rx_pop | output | 1 | One-cycle receive FIFO read pulse |
| tx_push | output | 1 | One-cycle transmit FIFO write pulse |

## Verification
The vector table drives several mixes of count, acknowledge, strobe and decode inputs. These show a plain nonzero count, a count of one with no access, an acknowledge with no strobe, a strobe with no acknowledge, and both acknowledges together with decode_hit high. Together they separate a true access from a lone acknowledge, and the acknowledge override from normal decoding.

Directed sequences then run a last-word access on each side. They confirm that the request drops at once, stays down while the count is unchanged, and returns only when the count rises. One sequence has the count rise in the middle of an access. Pulse counters show that one access gives one pulse, and that an acknowledge paired with the wrong strobe, or with no strobe, gives none.

// File: rtl/dma_req_handshake.sv
module dma_req_handshake #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_free,
  input  logic             rx_ack_n,
  input  logic             tx_ack_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             decode_hit,
  output logic             rx_req,
  output logic             tx_req,
  output logic             rx_sel,
  output logic             tx_sel,
  output logic             reg_sel,
  output logic             rx_pop,
  output logic             tx_push
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

  logic rx_act, tx_act, rx_last, tx_last;
  logic rx_act_q, tx_act_q, rx_hold_q, tx_hold_q;
  logic [CNT_W-1:0] rx_prev_q, tx_prev_q;

  assign rx_act  = !rx_ack_n && !rd_n;
  assign tx_act  = !tx_ack_n && !wr_n;
  assign rx_last = rx_act && (rx_count == LAST);
  assign tx_last = tx_act && (tx_free == LAST);

  assign rx_req  = rst_n && (rx_count != '0) && !rx_hold_q && !rx_last;
  assign tx_req  = rst_n && (tx_free != '0) && !tx_hold_q && !tx_last;

  assign rx_sel  = !rx_ack_n;
  assign tx_sel  = !tx_ack_n;
  assign reg_sel = decode_hit && rx_ack_n && tx_ack_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_act_q  <= 1'b0;
      tx_act_q  <= 1'b0;
      rx_pop    <= 1'b0;
      tx_push   <= 1'b0;
      rx_hold_q <= 1'b0;
      tx_hold_q <= 1'b0;
      rx_prev_q <= '0;
      tx_prev_q <= '0;
    end else begin
      rx_act_q  <= rx_act;
      tx_act_q  <= tx_act;
      rx_pop    <= rx_act_q && !rx_act;
      tx_push   <= tx_act_q && !tx_act;
      rx_prev_q <= rx_count;
      tx_prev_q <= tx_free;
      if (rx_last)                    rx_hold_q <= 1'b1;
      else if (rx_count > rx_prev_q)  rx_hold_q <= 1'b0;
      if (tx_last)                    tx_hold_q <= 1'b1;
      else if (tx_free > tx_prev_q)   tx_hold_q <= 1'b0;
    end
  end

endmodule

// File: rtl/dma_req_handshake_chk.sv
module dma_req_handshake_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] rx_count,
  input logic [CNT_W-1:0] tx_free,
  input logic             rx_ack_n,
  input logic             tx_ack_n,
  input logic             rd_n,
  input logic             wr_n,
  input logic             decode_hit,
  input logic             rx_req,
  input logic             tx_req,
  input logic             reg_sel,
  input logic             rx_pop,
  input logic             tx_push
);

  // R2
  rx_last_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ack_n && !rd_n && rx_count == CNT_W'(1)) |-> !rx_req);

  // R7
  tx_last_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ack_n && !wr_n && tx_free == CNT_W'(1)) |-> !tx_req);

  // R4
  rx_pop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |=> !rx_pop);

  // R9
  tx_push_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |=> !tx_push);

  // R5
  reg_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ack_n || !tx_ack_n) |-> !reg_sel);

  // R3
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!rx_ack_n && !rd_n && rx_count == CNT_W'(1)) && rx_count <= $past(rx_count)) |-> !rx_req);

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!rx_req && !tx_req && !rx_pop && !tx_push));

endmodule

bind dma_req_handshake dma_req_handshake_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_free(tx_free),
  .rx_ack_n(rx_ack_n), .tx_ack_n(tx_ack_n), .rd_n(rd_n), .wr_n(wr_n),
  .decode_hit(decode_hit), .rx_req(rx_req), .tx_req(tx_req),
  .reg_sel(reg_sel), .rx_pop(rx_pop), .tx_push(tx_push)
);

// File: tb/dma_req_handshake_bench.sv
module dma_req_handshake_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 5;
  localparam int NVEC = 10;

  typedef struct packed {
    logic [CNT_W-1:0] rc;
    logic [CNT_W-1:0] tf;
    logic rxa, txa, rd, wr, hit;
    logic e_rxr, e_txr, e_rs, e_ts, e_rg;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{5'd0, 5'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{5'd3, 5'd5, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    '{5'd1, 5'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    '{5'd4, 5'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    '{5'd4, 5'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    '{5'd1, 5'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    '{5'd2, 5'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    '{5'd2, 5'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    '{5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{5'd7, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0] rx_count = '0;
  logic [CNT_W-1:0] tx_free = '0;
  logic rx_ack_n = 1'b1, tx_ack_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, decode_hit = 1'b0;
  logic rx_req, tx_req, rx_sel, tx_sel, reg_sel, rx_pop, tx_push;

  int nvec = 0;
  int nfail = 0;
  int rx_pops = 0;
  int tx_pushes = 0;
  int base;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_req_handshake #(.CNT_W(CNT_W)) u_dma_req_handshake (
    .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_free(tx_free),
    .rx_ack_n(rx_ack_n), .tx_ack_n(tx_ack_n), .rd_n(rd_n), .wr_n(wr_n),
    .decode_hit(decode_hit), .rx_req(rx_req), .tx_req(tx_req),
    .rx_sel(rx_sel), .tx_sel(tx_sel), .reg_sel(reg_sel),
    .rx_pop(rx_pop), .tx_push(tx_push)
  );

  always @(negedge clk) begin
    if (rx_pop) rx_pops++;
    if (tx_push) tx_pushes++;
  end

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic chk_int(input string tag, input string what, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    rx_ack_n = 1'b1; tx_ack_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    nvec++;
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rx_count = 5'd5; tx_free = 5'd5;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "rx_req in reset", rx_req, 1'b0);
    chk("R11", "tx_req in reset", tx_req, 1'b0);
    chk("R11", "rx_pop in reset", rx_pop, 1'b0);
    chk("R11", "tx_push in reset", tx_push, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      rx_count = VECS[i].rc; tx_free = VECS[i].tf;
      rx_ack_n = VECS[i].rxa; tx_ack_n = VECS[i].txa;
      rd_n = VECS[i].rd; wr_n = VECS[i].wr; decode_hit = VECS[i].hit;
      #1;
      chk("R1", "rx_req", rx_req, VECS[i].e_rxr);
      chk("R6", "tx_req", tx_req, VECS[i].e_txr);
      chk("R5", "rx_sel", rx_sel, VECS[i].e_rs);
      chk("R5", "tx_sel", tx_sel, VECS[i].e_ts);
      chk("R10", "reg_sel", reg_sel, VECS[i].e_rg);
    end

    @(negedge clk);
    idle(); rx_count = '0; tx_free = '0; decode_hit = 1'b0;
    repeat (3) @(negedge clk);

    // receive last word
    base = rx_pops;
    rx_count = 5'd1; #1;
    chk("R1", "rx_req with one word", rx_req, 1'b1);
    @(negedge clk);
    rx_ack_n = 1'b0; rd_n = 1'b0; #1;
    chk("R2", "rx_req at last read start", rx_req, 1'b0);
    @(negedge clk);
    chk("R4", "rx_pop during access", rx_pop, 1'b0);
    idle(); #1;
    chk("R3", "rx_req held after last read", rx_req, 1'b0);
    @(negedge clk);
    chk("R4", "rx_pop after completion", rx_pop, 1'b1);
    @(negedge clk);
    chk("R4", "rx_pop one cycle wide", rx_pop, 1'b0);
    chk("R3", "rx_req held with count unchanged", rx_req, 1'b0);
    chk_int("R4", "rx_pop count for one read", rx_pops - base, 1);
    rx_count = '0;
    @(negedge clk);
    rx_count = 5'd1; #1;
    chk("R3", "rx_req before edge sees rise", rx_req, 1'b0);
    @(negedge clk);
    chk("R3", "rx_req after new word", rx_req, 1'b1);

    // receive acknowledge without read strobe
    base = rx_pops;
    rx_count = 5'd3; rx_ack_n = 1'b0; wr_n = 1'b0;
    repeat (2) @(negedge clk);
    idle();
    repeat (3) @(negedge clk);
    chk_int("R4", "rx_pop without read strobe", rx_pops - base, 0);

    // new word arrives during last-word read
    rx_count = 5'd1; rx_ack_n = 1'b0; rd_n = 1'b0; #1;
    chk("R2", "rx_req drop before arrival", rx_req, 1'b0);
    @(negedge clk);
    rx_count = 5'd2;
    @(negedge clk);
    chk("R3", "rx_req after arrival mid-read", rx_req, 1'b1);
    idle();
    repeat (3) @(negedge clk);
    rx_count = '0;

    // transmit last slot
    base = tx_pushes;
    tx_free = 5'd1; #1;
    chk("R6", "tx_req with one slot", tx_req, 1'b1);
    @(negedge clk);
    tx_ack_n = 1'b0; wr_n = 1'b0; #1;
    chk("R7", "tx_req at last write start", tx_req, 1'b0);
    @(negedge clk);
    chk("R9", "tx_push during access", tx_push, 1'b0);
    idle(); #1;
    chk("R8", "tx_req held after last write", tx_req, 1'b0);
    @(negedge clk);
    chk("R9", "tx_push after completion", tx_push, 1'b1);
    @(negedge clk);
    chk("R9", "tx_push one cycle wide", tx_push, 1'b0);
    chk("R8", "tx_req held with space unchanged", tx_req, 1'b0);
    chk_int("R9", "tx_push count for one write", tx_pushes - base, 1);
    tx_free = '0;
    @(negedge clk);
    tx_free = 5'd2;
    @(negedge clk);
    chk("R8", "tx_req after space freed", tx_req, 1'b1);

    // transmit acknowledge with read strobe only, then with no strobe
    base = tx_pushes;
    tx_ack_n = 1'b0; rd_n = 1'b0;
    repeat (2) @(negedge clk);
    rd_n = 1'b1;
    repeat (2) @(negedge clk);
    idle();
    repeat (3) @(negedge clk);
    chk_int("R9", "tx_push without write strobe", tx_pushes - base, 0);

    // R5 acknowledge overrides decode
    decode_hit = 1'b1; tx_ack_n = 1'b0; #1;
    chk("R5", "reg_sel blocked by tx ack", reg_sel, 1'b0);
    chk("R5", "tx_sel with tx ack", tx_sel, 1'b1);
    idle(); #1;
    chk("R10", "reg_sel after ack release", reg_sel, 1'b1);

    @(negedge clk);
    finish_run();
  end
endmodule